// File: doc/BRIEF.md
# Byte-Serial ROM Address Loader

This block connects a host that has only an 8-bit data bus and a 2-bit select code to a parallel ROM whose address is wider than that bus. The host builds the ROM address one byte at a time. It puts a byte on its bus, chooses which address byte it is with the select code, and pulses a write strobe. Each address byte sits in its own register, and the registers together drive the ROM address pins.

When the address is complete, the host stops driving its bus and sets the select code to its highest value. The block then turns on the ROM output and passes the ROM byte back to the host. After a configurable access time it flags the byte as valid. The host repeats the whole sequence for every address it wants to read. It may skip the third address byte when the ROM needs no more than 16 address bits.

The select code is decoded one-hot. Each code value picks exactly one destination: one of the three address registers, or the ROM read path. The ROM output is never enabled while the host is still driving the shared bus.

Top module: `rom_addr_loader`

## Requirements
- R1: While `rst` is high at a clock edge, `rom_addr` clears to zero from that edge onward. `rom_oe`, `host_data_oe` and `host_data_valid` are 0 after reset.
- R2: A clock edge with `host_wr`=1, `host_dir_in`=0 and `host_sel`=0 loads `host_data_in` into `rom_addr[7:0]`.
- R3: A clock edge with `host_wr`=1, `host_dir_in`=0 and `host_sel`=1 loads `host_data_in` into `rom_addr[15:8]`.
- R4: A clock edge with `host_wr`=1, `host_dir_in`=0 and `host_sel`=2 loads `host_data_in` into `rom_addr[23:16]`. Skipping this write leaves those bits at their previous value.
- R5: A strobe with `host_sel`=3, or a strobe while `host_dir_in`=1, changes no bit of `rom_addr`.
- R6: `rom_oe` and `host_data_oe` are 1 exactly when `host_sel`=3 and `host_dir_in`=1. They fall in the same cycle that either condition goes away.
- R7: `host_data_out` equals `rom_data` while `host_data_oe` is 1, and is all zeros otherwise.
- R8: `host_data_valid` becomes 1 after `ACCESS_LAT` clock edges with `rom_oe` held continuously at 1. It is 0 before that, and 0 whenever `rom_oe` is 0. Leaving the read state and returning starts the count again from zero.
- R9: When no strobe is given, or a strobe targets a different register, an address byte register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Destination code: 0 low byte, 1 middle byte, 2 upper byte, 3 ROM read |
| host_wr | input | 1 | Write strobe for the selected address byte |
| host_dir_in | input | 1 | 1 when the host has released its bus and is reading |
| host_data_in | input | 8 | Byte driven by the host |
| host_data_out | output | 8 | ROM byte returned to the host |
| host_data_oe | output | 1 | Block drives the host bus |
| host_data_valid | output | 1 | Returned byte has met the access time |
| rom_addr | output | 24 | ROM address |
| rom_oe | output | 1 | ROM output enable |
| rom_data | input | 8 | ROM data pins |

## Verification
The hardest situations to reach are a read state that is interrupted before the access time has passed, and strobes given while the host has already turned its bus around. The table-driven loop covers full address sequences, both with and without the optional third byte. The directed tests leave code 3 partway through the latency count and then return, checking that the valid flag waits a full `ACCESS_LAT` edges again. They also pulse the strobe with direction set to input, and with code 3 selected, and read the address back at the ROM pins.

// File: rtl/rom_loader_pkg.sv
package rom_loader_pkg;
  localparam int unsigned LDR_BYTE_W    = 8;
  localparam int unsigned LDR_SEL_W     = 2;
  localparam int unsigned LDR_ADDR_BYTES = 3;
  localparam int unsigned LDR_ACCESS_LAT = 3;

  typedef enum logic [LDR_SEL_W-1:0] {
    SEL_ADDR_LO  = 2'd0,
    SEL_ADDR_MID = 2'd1,
    SEL_ADDR_UP  = 2'd2,
    SEL_READ     = 2'd3
  } ldr_sel_e;
endpackage

// File: rtl/ldr_sel_decoder.sv
module ldr_sel_decoder #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned N_DEST = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [N_DEST-1:0] dest
);
  for (genvar d = 0; d < N_DEST; d++) begin : g_dec
    assign dest[d] = (sel == d[SEL_W-1:0]);
  end
endmodule

// File: rtl/ldr_addr_byte.sv
module ldr_addr_byte #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/ldr_access_timer.sv
module ldr_access_timer #(
  parameter int unsigned ACCESS_LAT = 3,
  localparam int unsigned CNT_W = (ACCESS_LAT < 1) ? 1 : $clog2(ACCESS_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic ready
);
  localparam logic [CNT_W-1:0] LAT_V = CNT_W'(ACCESS_LAT);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active)  cnt <= '0;
    else if (cnt != LAT_V) cnt <= cnt + 1'b1;
  end

  // Combine with the live enable so a drop ends validity in the same cycle
  assign ready = active && (cnt == LAT_V);
endmodule

// File: rtl/rom_addr_loader.sv
module rom_addr_loader
  import rom_loader_pkg::*;
#(
  parameter int unsigned BYTE_W     = LDR_BYTE_W,
  parameter int unsigned SEL_W      = LDR_SEL_W,
  parameter int unsigned ADDR_BYTES = LDR_ADDR_BYTES,
  parameter int unsigned ACCESS_LAT = LDR_ACCESS_LAT,
  localparam int unsigned ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int unsigned N_DEST    = 1 << SEL_W,
  localparam int unsigned READ_CODE = N_DEST - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic              host_wr,
  input  logic              host_dir_in,
  input  logic [BYTE_W-1:0] host_data_in,
  output logic [BYTE_W-1:0] host_data_out,
  output logic              host_data_oe,
  output logic              host_data_valid,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_oe,
  input  logic [BYTE_W-1:0] rom_data
);
  logic [N_DEST-1:0] dest;
  logic              host_drives;

  ldr_sel_decoder #(.SEL_W(SEL_W)) u_dec (
    .sel  (host_sel),
    .dest (dest)
  );

  assign host_drives = !host_dir_in;

  // One register per address byte; the read code never reaches one
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    ldr_addr_byte #(.BYTE_W(BYTE_W)) u_byte (
      .clk  (clk),
      .rst  (rst),
      .load (host_wr && host_drives && dest[b]),
      .din  (host_data_in),
      .q    (rom_addr[b*BYTE_W +: BYTE_W])
    );
  end

  // Bus turnaround: ROM drives only after the host lets go
  assign rom_oe        = dest[READ_CODE] && host_dir_in;
  assign host_data_oe  = rom_oe;
  assign host_data_out = rom_oe ? rom_data : '0;

  ldr_access_timer #(.ACCESS_LAT(ACCESS_LAT)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (rom_oe),
    .ready  (host_data_valid)
  );
endmodule

// File: rtl/rom_addr_loader_chk.sv
module rom_addr_loader_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  host_sel,
  input logic              host_wr,
  input logic              host_dir_in,
  input logic [BYTE_W-1:0] host_data_in,
  input logic [BYTE_W-1:0] host_data_out,
  input logic              host_data_oe,
  input logic              host_data_valid,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_oe,
  input logic [BYTE_W-1:0] rom_data
);
  localparam logic [SEL_W-1:0] RD = '1;

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (rom_addr == '0));
  // R2
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_dir_in && host_sel == '0) |=> (rom_addr[BYTE_W-1:0] == $past(host_data_in)));
  // R5
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_wr || host_dir_in || host_sel == RD) |=> $stable(rom_addr));
  // R6
  oe_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
    rom_oe |-> (host_dir_in && host_sel == RD));
  // R6
  oe_same_as_bus_chk: assert property (@(posedge clk) disable iff (rst)
    host_data_oe == rom_oe);
  // R7
  data_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    host_data_oe |-> (host_data_out == rom_data));
  // R8
  valid_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    host_data_valid |-> rom_oe);
endmodule

bind rom_addr_loader rom_addr_loader_chk #(
  .BYTE_W(BYTE_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
  .host_dir_in(host_dir_in), .host_data_in(host_data_in),
  .host_data_out(host_data_out), .host_data_oe(host_data_oe),
  .host_data_valid(host_data_valid), .rom_addr(rom_addr),
  .rom_oe(rom_oe), .rom_data(rom_data)
);

// File: tb/rom_addr_loader_tb.sv
`timescale 1ns/1ps
module rom_addr_loader_tb;
  localparam int LAT = 3;
  localparam int NV  = 8;
  // {use_upper, upper, middle, low}
  localparam logic [24:0] VEC [NV] = '{
    25'h1_000000, 25'h1_123456, 25'h0_00FF01, 25'h1_A5C3E7,
    25'h0_8001FE, 25'h1_FFFFFF, 25'h1_3C0000, 25'h0_0055AA
  };

  logic clk = 0, rst = 1;
  logic [1:0] host_sel = 0;
  logic host_wr = 0, host_dir_in = 0;
  logic [7:0] host_data_in = 0, host_data_out, rom_data;
  logic host_data_oe, host_data_valid, rom_oe;
  logic [23:0] rom_addr;
  logic [23:0] exp_addr;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] romf(input logic [23:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction
  assign rom_data = romf(rom_addr);

  rom_addr_loader u_dut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_dir_in(host_dir_in), .host_data_in(host_data_in),
    .host_data_out(host_data_out), .host_data_oe(host_data_oe),
    .host_data_valid(host_data_valid), .rom_addr(rom_addr),
    .rom_oe(rom_oe), .rom_data(rom_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called right after a negedge; leaves strobe low at the next negedge
  task automatic wr_byte(input logic [1:0] s, input logic [7:0] v, input logic dir);
    host_sel = s; host_dir_in = dir; host_data_in = v; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic do_read(input string tag);
    host_dir_in = 1; host_sel = 2'd3;
    #1;
    chk({tag, " R6 oe"}, {30'd0, rom_oe, host_data_oe}, 32'h3);
    chk({tag, " R8 early"}, host_data_valid, 0);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      chk({tag, " R8 count"}, host_data_valid, (k == LAT));
    end
    chk({tag, " R7 data"}, host_data_out, romf(exp_addr));
    host_sel = 2'd0;
    #1;
    chk({tag, " R6 drop"}, {30'd0, rom_oe, host_data_oe}, 0);
    chk({tag, " R7 zero"}, {host_data_out, 7'd0, host_data_valid}, 0);
    host_dir_in = 0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_addr = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 addr", rom_addr, 0);
    chk("R1 outs", {rom_oe, host_data_oe, host_data_valid}, 0);
    @(negedge clk);

    // table walk: R2 R3 R4 R7 R8
    for (int i = 0; i < NV; i++) begin
      wr_byte(2'd0, VEC[i][7:0], 0);   exp_addr[7:0]  = VEC[i][7:0];
      chk("R2 low", rom_addr, exp_addr);
      wr_byte(2'd1, VEC[i][15:8], 0);  exp_addr[15:8] = VEC[i][15:8];
      chk("R3 mid", rom_addr, exp_addr);
      if (VEC[i][24]) begin
        wr_byte(2'd2, VEC[i][23:16], 0); exp_addr[23:16] = VEC[i][23:16];
      end
      chk("R4 upper", rom_addr, exp_addr);
      do_read("vec");
    end

    // R5: strobe with read code while driving
    wr_byte(2'd3, 8'hEE, 0);
    chk("R5 code3", rom_addr, exp_addr);
    // R5: strobe on each address code while bus released
    for (int s = 0; s < 3; s++) begin
      wr_byte(s[1:0], 8'h77, 1);
      chk("R5 dirin", rom_addr, exp_addr);
    end
    host_dir_in = 0;
    // R9: data changes with no strobe
    host_sel = 2'd1; host_data_in = 8'h99;
    repeat (2) @(negedge clk);
    chk("R9 hold", rom_addr, exp_addr);
    // R9: strobe to low byte leaves the others
    wr_byte(2'd0, 8'h42, 0); exp_addr[7:0] = 8'h42;
    chk("R9 others", rom_addr, exp_addr);

    // R6: code 3 while host still drives
    host_sel = 2'd3; host_dir_in = 0; #1;
    chk("R6 no release", {rom_oe, host_data_oe}, 0);
    chk("R7 gated", host_data_out, 0);
    @(negedge clk);

    // R8: interrupt before latency, return restarts count
    host_dir_in = 1;
    @(negedge clk);
    chk("R8 partial", host_data_valid, 0);
    host_dir_in = 0; #1;
    chk("R6 dir back", rom_oe, 0);
    @(negedge clk);
    do_read("restart");

    // R1: reset mid-address clears
    wr_byte(2'd2, 8'hC4, 0);
    rst = 1; @(negedge clk); rst = 0;
    exp_addr = 0;
    chk("R1 midrun", rom_addr, 0);
    do_read("post-reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule